// File: doc/BRIEF.md
# Bidirectional GPIO Port with Change Interrupt

This block is an eight-pin general purpose I/O port behind a small register interface. Software sets a direction bit and an output value for each pin. A pin set as output has its tri-state enable asserted and drives the latched value. A pin set as input floats, and it may have a weak pull-up. One global active-low control turns the pull-ups on, and the pull-up of a pin that is currently an output is always forced off. A peripheral can take over the direction of any pin through per-pin override inputs.

The upper pins (7 down to 4) can raise a change interrupt. Each such pin that is an input is compared with a snapshot. The snapshot is loaded each time software reads the pin levels. Any difference sets a sticky flag, and the flag stays set for as long as the difference remains. To clear it, software first reads the port and then writes the clear. A wake output reports the flag or a live difference, so the system can leave a sleep state.

Top module: `gpio_chg_port`

## Requirements
- R1: The effective direction bit decides each pin. A 1 makes the pin an input: `pad_oe_o` is 0. A 0 makes it an output: `pad_oe_o` is 1. `pad_o` always carries the output latch. The latch is written at register address 0 or 3, and the direction at address 1.
- R2: `pull_en_o[b]` is 1 only when pin b is an effective input and bit 0 (pull-up off) of the control register at address 2 is 0.
- R3: No pin has its pull-up enable and its output enable asserted together.
- R4: When `ovr_en_i[b]` is 1, the effective direction of pin b is `ovr_dir_i[b]` (1 means input), whatever the direction register holds.
- R5: The read data depends on the address. Address 0 returns the pin levels after a two-flop synchronizer. Address 1 returns the direction register. Address 2 returns {6'b0, flag, pull-up-off}. Address 3 returns the output latch.
- R6: After reset the direction register is all ones, the output latch is 0, the pull-up-off bit is 1, and the change flag and the snapshot are 0.
- R7: Only pins 7 to 4 take part in change detection, and only while they are effective inputs. A port read (address 0) loads the snapshot with the synchronized levels.
- R8: If any participating pin differs from its snapshot, the flag is 1 after the next clock edge. It keeps being set while the difference lasts. `irq_o` shows the flag.
- R9: A write to address 2 with bit 1 at 0 clears the flag unless a difference is present in the same cycle, in which case the flag stays 1. Writing bit 1 as 1 has no effect on the flag.
- R10: `wake_o` is 1 whenever the flag is set or a difference is currently present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| ovr_en_i | input | 8 | Per-pin peripheral direction override enable |
| ovr_dir_i | input | 8 | Override direction, 1 means input |
| pad_i | input | 8 | Pin levels from the pads |
| pad_o | output | 8 | Output latch value to the pads |
| pad_oe_o | output | 8 | Per-pin output driver enable |
| pull_en_o | output | 8 | Per-pin weak pull-up enable |
| irq_o | output | 1 | Change interrupt flag |
| wake_o | output | 1 | Wake request |

## Verification
The assertions check the following on every cycle. Pull-up and driver enables never overlap. An override decides the pad enable. A live difference sets the flag on the next edge. The flag only rises after a difference, and it only falls after a clear write. The bench scenarios show what a property cannot. A read refreshes the snapshot and ends the difference. Clearing without a read fails. The low pins and any pin set as output are ignored. Values pass through the synchronizer with the right latency. All of this runs against a cycle model under random register traffic and random pin activity.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_PORT = 2'd0,
    REG_DIR  = 2'd1,
    REG_CTRL = 2'd2,
    REG_LAT  = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_PUOFF_BIT = 0;
  localparam int unsigned CTRL_FLAG_BIT  = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] pins_sync_i,
  input  logic             flag_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [WIDTH-1:0] out_q_o,
  output logic [WIDTH-1:0] dir_q_o,
  output logic             pu_off_o,
  output logic             port_rd_o,
  output logic             flag_clr_o
);
  reg_addr_e addr;
  logic      wr, rd;
  logic [WIDTH-1:0] out_q, dir_q;
  logic             pu_off_q;

  assign addr = reg_addr_e'(addr_i);
  assign wr   = req_i & we_i;
  assign rd   = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= '0;
      dir_q    <= '1;
      pu_off_q <= 1'b1;
    end else if (wr) begin
      unique case (addr)
        REG_PORT, REG_LAT: out_q    <= wdata_i;
        REG_DIR:           dir_q    <= wdata_i;
        REG_CTRL:          pu_off_q <= wdata_i[CTRL_PUOFF_BIT];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      REG_PORT: rdata_o = pins_sync_i;
      REG_DIR:  rdata_o = dir_q;
      REG_CTRL: begin
        rdata_o[CTRL_PUOFF_BIT] = pu_off_q;
        rdata_o[CTRL_FLAG_BIT]  = flag_i;
      end
      REG_LAT:  rdata_o = out_q;
      default: ;
    endcase
  end

  assign port_rd_o  = rd & (addr == REG_PORT);
  assign flag_clr_o = wr & (addr == REG_CTRL) & ~wdata_i[CTRL_FLAG_BIT];
  assign out_q_o    = out_q;
  assign dir_q_o    = dir_q;
  assign pu_off_o   = pu_off_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q_i,
  input  logic [WIDTH-1:0] out_q_i,
  input  logic [WIDTH-1:0] ovr_en_i,
  input  logic [WIDTH-1:0] ovr_dir_i,
  input  logic             pu_off_i,
  output logic [WIDTH-1:0] eff_dir_o,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pull_en_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    logic is_in;
    // peripheral override beats the direction latch
    assign is_in        = ovr_en_i[b] ? ovr_dir_i[b] : dir_q_i[b];
    assign eff_dir_o[b] = is_in;
    assign pad_oe_o[b]  = ~is_in;
    assign pad_o[b]     = out_q_i[b];
    assign pull_en_o[b] = is_in & ~pu_off_i;
  end
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int unsigned CHG_N = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CHG_N-1:0] pins_i,
  input  logic [CHG_N-1:0] is_in_i,
  input  logic             port_rd_i,
  input  logic             flag_clr_i,
  output logic             flag_o,
  output logic             mism_o
);
  logic [CHG_N-1:0] snap_q, mism;
  logic             flag_q;

  assign mism   = (pins_i ^ snap_q) & is_in_i;
  assign mism_o = |mism;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (port_rd_i) snap_q <= pins_i;
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (mism_o)     flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned CHG_LO      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] ovr_en_i,
  input  logic [WIDTH-1:0] ovr_dir_i,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pull_en_o,
  output logic             irq_o,
  output logic             wake_o
);
  localparam int unsigned CHG_N = WIDTH - CHG_LO;

  logic [WIDTH-1:0] pins_sync, out_q, dir_q, eff_dir;
  logic             pu_off, port_rd, flag_clr, flag, mism;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pins_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .pins_sync_i(pins_sync),
    .flag_i     (flag),
    .rdata_o    (rdata_o),
    .out_q_o    (out_q),
    .dir_q_o    (dir_q),
    .pu_off_o   (pu_off),
    .port_rd_o  (port_rd),
    .flag_clr_o (flag_clr)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .dir_q_i  (dir_q),
    .out_q_i  (out_q),
    .ovr_en_i (ovr_en_i),
    .ovr_dir_i(ovr_dir_i),
    .pu_off_i (pu_off),
    .eff_dir_o(eff_dir),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o),
    .pull_en_o(pull_en_o)
  );

  gpio_chg_detect #(.CHG_N(CHG_N)) u_chg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pins_i    (pins_sync[WIDTH-1:CHG_LO]),
    .is_in_i   (eff_dir[WIDTH-1:CHG_LO]),
    .port_rd_i (port_rd),
    .flag_clr_i(flag_clr),
    .flag_o    (flag),
    .mism_o    (mism)
  );

  assign irq_o  = flag;
  assign wake_o = flag | mism;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic             clr_bit_i,
  input logic [WIDTH-1:0] ovr_en_i,
  input logic [WIDTH-1:0] ovr_dir_i,
  input logic [WIDTH-1:0] pad_oe_o,
  input logic [WIDTH-1:0] pull_en_o,
  input logic             irq_o,
  input logic             wake_o
);
  assert_pull_off_on_output_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pull_en_o) == '0);

  assert_override_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_en_i & (pad_oe_o ^ ~ovr_dir_i)) == '0);

  assert_mism_sets_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !irq_o) |=> irq_o);

  assert_flag_fall_needs_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(req_i && we_i && addr_i == 2'd2 && !clr_bit_i));

  assert_flag_rise_has_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(wake_o));
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .clr_bit_i(wdata_i[1]),
  .ovr_en_i (ovr_en_i),
  .ovr_dir_i(ovr_dir_i),
  .pad_oe_o (pad_oe_o),
  .pull_en_o(pull_en_o),
  .irq_o    (irq_o),
  .wake_o   (wake_o)
);

// File: tb/tb_gpio_chg_port.sv
`timescale 1ns/1ps
module tb_gpio_chg_port;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00, ovr_en_i = 8'h00, ovr_dir_i = 8'h00, pad_i = 8'h00;
  logic [7:0] rdata_o, pad_o, pad_oe_o, pull_en_o;
  logic       irq_o, wake_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  gpio_chg_port dut (.*);

  // cycle model
  logic [7:0] m_s1, m_s2, m_out, m_dir;
  logic [3:0] m_snap;
  logic       m_flag, m_puoff;

  function automatic logic [7:0] eff_dir();
    return (ovr_en_i & ovr_dir_i) | (~ovr_en_i & m_dir);
  endfunction
  function automatic logic [3:0] mism();
    logic [7:0] e = eff_dir();
    return (m_s2[7:4] ^ m_snap) & e[7:4];
  endfunction
  function automatic logic [7:0] exp_rdata();
    case (addr_i)
      2'd0: return m_s2;
      2'd1: return m_dir;
      2'd2: return {6'b0, m_flag, m_puoff};
      default: return m_out;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 <= 0; m_s2 <= 0; m_out <= 0; m_dir <= 8'hFF;
      m_snap <= 0; m_flag <= 0; m_puoff <= 1;
    end else begin
      m_s1 <= pad_i; m_s2 <= m_s1;
      if (req_i && !we_i && addr_i == 2'd0) m_snap <= m_s2[7:4];
      if (|mism()) m_flag <= 1;
      else if (req_i && we_i && addr_i == 2'd2 && !wdata_i[1]) m_flag <= 0;
      if (req_i && we_i) begin
        case (addr_i)
          2'd0, 2'd3: m_out <= wdata_i;
          2'd1: m_dir <= wdata_i;
          default: m_puoff <= wdata_i[0];
        endcase
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) if (rst_ni && !done) begin
    logic [7:0] e;
    e = eff_dir();
    chk("R1 oe", pad_oe_o, ~e);
    chk("R1 pad", pad_o, m_out);
    chk("R2 pull", pull_en_o, e & {8{~m_puoff}});
    chk("R5 rdata", rdata_o, exp_rdata());
    chk("R8 irq", {7'b0, irq_o}, {7'b0, m_flag});
    chk("R10 wake", {7'b0, wake_o}, {7'b0, m_flag | (|mism())});
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk_i);
    #1;
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    cyc(); req_i = 0; we_i = 0;
  endtask
  task automatic rd(logic [1:0] a);
    req_i = 1; we_i = 0; addr_i = a;
    cyc(); req_i = 0;
  endtask

  initial begin
    repeat (300000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finish");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3); rst_ni = 1; cyc();
    // R6 reset state
    addr_i = 2'd1; #0.1 chk("R6 dir reset", rdata_o, 8'hFF);
    addr_i = 2'd2; #0.1 chk("R6 ctrl reset", rdata_o, 8'h01);
    addr_i = 2'd3; #0.1 chk("R6 lat reset", rdata_o, 8'h00);
    chk("R6 pull off", pull_en_o, 8'h00);
    chk("R6 irq", {7'b0, irq_o}, 8'h00);
    // R1 direction / latch
    wr(2'd1, 8'hCF); wr(2'd3, 8'h35);
    chk("R1 oe", pad_oe_o, 8'h30); chk("R1 pad", pad_o, 8'h35);
    // R2 R3 pull-ups
    wr(2'd2, 8'h02);
    chk("R2 pull", pull_en_o, 8'hCF);
    chk("R3 excl", pull_en_o & pad_oe_o, 8'h00);
    // R4 override
    ovr_en_i = 8'h11; ovr_dir_i = 8'h10; cyc();
    chk("R4 oe", pad_oe_o, 8'h21); chk("R4 pull", pull_en_o, 8'hDE);
    ovr_en_i = 0;
    // R7 R8 R9 change flow
    wr(2'd1, 8'hFF); pad_i = 8'h00; cyc(3); rd(2'd0); wr(2'd2, 8'h01);
    chk("R9 clear", {7'b0, irq_o}, 8'h00);
    pad_i = 8'h01; cyc(4);
    chk("R7 low bit ignored", {7'b0, irq_o}, 8'h00);
    addr_i = 2'd0; #0.1 chk("R5 sync read", rdata_o, 8'h01);
    pad_i = 8'h81; cyc(2);
    chk("R10 wake live", {7'b0, wake_o}, 8'h01);
    cyc();
    chk("R8 flag set", {7'b0, irq_o}, 8'h01);
    wr(2'd2, 8'h01);
    chk("R9 set wins", {7'b0, irq_o}, 8'h01);
    wr(2'd2, 8'h03);
    chk("R9 bit1=1 no effect", {7'b0, irq_o}, 8'h01);
    rd(2'd0); wr(2'd2, 8'h01);
    chk("R9 read then clear", {7'b0, irq_o}, 8'h00);
    chk("R10 wake idle", {7'b0, wake_o}, 8'h00);
    // R7 output pin excluded
    wr(2'd1, 8'hBF); pad_i = 8'hC1; cyc(4);
    chk("R7 output excluded", {7'b0, irq_o}, 8'h00);
    // random phase
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 2) pad_i[7:4] = 4'($urandom);
      else if (sel < 3) pad_i = 8'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        ovr_en_i = 8'($urandom); ovr_dir_i = 8'($urandom);
      end
      req_i = $urandom_range(0, 1); we_i = $urandom_range(0, 1);
      addr_i = 2'($urandom); wdata_i = 8'($urandom);
      cyc();
    end
    req_i = 0;
    cyc(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule